// File: doc/BRIEF.md
# Five-Source Interrupt Controller

This block gathers interrupt requests from five sources and presents at most one of them to a small processor core. The five sources are two active-low external pins, two timer overflow requests and one serial port request. Each external pin passes through a synchronizer. It is then latched either as a level or as a falling edge, and the choice is made per pin by a configuration bit.

A single configuration write port loads two registers. The first holds one enable bit per source and a global enable bit. The second holds the trigger type of each external pin. Every cycle, the block masks the pending sources and picks the highest-priority survivor under a fixed order. It then drives a registered request together with that source's fixed vector address. When the core raises the acknowledge input, the block drops the request for one cycle and clears the latched flag of an edge-triggered source. Level-type sources stay pending until the source itself withdraws the request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `irq_req` is 0, `irq_vec` is 0000h, all enable bits are 0 and both external pins are in level mode.
- R2: A write with `cfg_addr`=0 loads the enable register: bit 0 enables external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, and bit 7 is the global enable. A write with `cfg_addr`=1 loads the type register: bit 0 puts external 0 in edge mode and bit 1 puts external 1 in edge mode (0 means level).
- R3: In level mode an external source is pending exactly while its pin is low, with the synchronizer delay, so the request goes away once the pin returns high.
- R4: In edge mode a falling edge on the pin sets the source's flag, and the flag stays set after the pin goes high again until it is acknowledged.
- R5: When `irq_ack` is 1 while `irq_req` is 1, `irq_req` is 0 in the next cycle, and the flag of the presented source is cleared if that source is an edge-mode external pin.
- R6: When several enabled sources are pending, the one presented follows the fixed order external 0, timer 0, external 1, timer 1, serial (first is highest).
- R7: The vector is 0003h, 000Bh, 0013h, 001Bh or 0023h for the sources in the order of R6.
- R8: With the global enable at 0, no request is issued. Pending flags, including edge-latched ones, are kept, and the request appears two cycles after the global enable is written to 1.
- R9: A source whose enable bit is 0 is never presented; the next enabled pending source is presented instead.
- R10: With the default two synchronizer stages, a pin falling while its source is enabled gives `irq_req`=1 at the fourth rising clock edge after the change and not before.
- R11: The timer and serial inputs are level requests owned by their sources: acknowledging one drops `irq_req` for one cycle, after which it is presented again while still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n | input | 2 | External interrupt pins, active low (bit 0 = external 0) |
| tmr_ovf | input | 2 | Timer overflow requests (bit 0 = timer 0) |
| ser_irq | input | 1 | Serial port request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = enable register, 1 = type register |
| cfg_wdata | input | 8 | Configuration write data |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 16 | Vector address of the presented source |
| irq_ack | input | 1 | Acknowledge from the core |

## Verification
The bench targets the edge flag that must outlive its pin pulse and a masked global enable. A design that clears flags on the pin's rise, or that discards them while masked, would lose the interrupt. It drives all five sources at once and withdraws them one by one, so a swapped priority position or a wrong vector stride shows up as a wrong vector. It also checks the exact cycle of the first request after a pin falls, which exposes a missing or extra synchronizer stage. It acknowledges both an edge source and a held serial request: an edge flag that survives an acknowledge, or a level request that does not come back, is reported.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC  = 5;
  localparam int IDX_W  = $clog2(N_SRC);
  // positions in the priority order (0 = highest)
  localparam int POS_EXT0 = 0;
  localparam int POS_TMR0 = 1;
  localparam int POS_EXT1 = 2;
  localparam int POS_TMR1 = 3;
  localparam int POS_SER  = 4;
  localparam int GLOB_BIT = 7;
endpackage

// File: rtl/irq_ext_latch.sv
module irq_ext_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic flag
);
  logic [SYNC_STAGES-1:0] sr;
  logic                   prev;
  logic                   synced;

  assign synced = sr[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '1;
      prev <= 1'b1;
      flag <= 1'b0;
    end else begin
      sr   <= {sr[SYNC_STAGES-2:0], pin_n};
      prev <= synced;
      if (!edge_mode)
        flag <= ~synced;
      else if (prev && !synced)
        flag <= 1'b1;
      else if (clr)
        flag <= 1'b0;
    end
  end

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && flag && !clr) |=> (flag || !edge_mode));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int          N        = 5,
  parameter int          VW       = 16,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter logic [15:0] VEC_STEP = 16'h0008,
  localparam int         IW       = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  en,
  input  logic          glob,
  input  logic          ack,
  output logic          req,
  output logic [VW-1:0] vec,
  output logic [IW-1:0] idx
);
  logic [N-1:0]  live;
  logic          any;
  logic [IW-1:0] win;

  assign live = glob ? (pend & en) : '0;
  assign any  = |live;

  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--)
      if (live[i]) win = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      vec <= '0;
      idx <= '0;
    end else if (ack && req) begin
      req <= 1'b0;
    end else begin
      req <= any;
      if (any) begin
        idx <= win;
        vec <= VW'(VEC_BASE + VEC_STEP * win);
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !req);
  // R8
  glob_off_chk: assert property (@(posedge clk) disable iff (rst)
    !glob |=> !req);
  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && req) |=> !req);
  // R7
  vec_align_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> (((vec - VW'(VEC_BASE)) % VW'(VEC_STEP)) == 0 &&
             vec <= VW'(VEC_BASE + VEC_STEP * (N - 1))));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int          SYNC_STAGES = 2,
  parameter int          VEC_W       = 16,
  parameter logic [15:0] VEC_BASE    = 16'h0003,
  parameter logic [15:0] VEC_STEP    = 16'h0008
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ext_irq_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_irq,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack
);
  import irq_pkg::*;

  logic [N_SRC-1:0] en_q;
  logic             glob_q;
  logic [1:0]       edge_q;
  logic [1:0]       ext_flag;
  logic [N_SRC-1:0] pend;
  logic [IDX_W-1:0] cur_idx;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      glob_q <= 1'b0;
      edge_q <= '0;
    end else if (cfg_we) begin
      if (!cfg_addr) begin
        en_q   <= cfg_wdata[N_SRC-1:0];
        glob_q <= cfg_wdata[GLOB_BIT];
      end else begin
        edge_q <= cfg_wdata[1:0];
      end
    end
  end

  localparam int EXT_POS [2] = '{POS_EXT0, POS_EXT1};

  for (genvar g = 0; g < 2; g++) begin : g_ext
    logic clr;
    assign clr = irq_ack && irq_req && (cur_idx == IDX_W'(EXT_POS[g]));
    irq_ext_latch #(.SYNC_STAGES(SYNC_STAGES)) u_lat (
      .clk      (clk),
      .rst      (rst),
      .pin_n    (ext_irq_n[g]),
      .edge_mode(edge_q[g]),
      .clr      (clr),
      .flag     (ext_flag[g])
    );
  end

  always_comb begin
    pend           = '0;
    pend[POS_EXT0] = ext_flag[0];
    pend[POS_TMR0] = tmr_ovf[0];
    pend[POS_EXT1] = ext_flag[1];
    pend[POS_TMR1] = tmr_ovf[1];
    pend[POS_SER]  = ser_irq;
  end

  irq_pick #(
    .N       (N_SRC),
    .VW      (VEC_W),
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP)
  ) u_pick (
    .clk (clk),
    .rst (rst),
    .pend(pend),
    .en  (en_q),
    .glob(glob_q),
    .ack (irq_ack),
    .req (irq_req),
    .vec (irq_vec),
    .idx (cur_idx)
  );

  // R9
  masked_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> en_q[cur_idx] || $past(cfg_we));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  ext_irq_n = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_irq = 0;
  logic        cfg_we = 0;
  logic        cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic        irq_ack = 0;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .tmr_ovf(tmr_ovf),
    .ser_irq(ser_irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack)
  );

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 0;
  endtask

  task automatic ack_pulse;
    irq_ack = 1; step(1); irq_ack = 0;
  endtask

  task automatic quiet;
    ext_irq_n = 2'b11; tmr_ovf = 0; ser_irq = 0;
    wr(0, 8'h00); wr(1, 8'h00); step(5);
  endtask

  task automatic t_reset;
    chk("R1 req", {15'd0, irq_req}, 16'd0);
    chk("R1 vec", irq_vec, 16'h0000);
    ser_irq = 1; step(3);
    chk("R1 enables cleared", {15'd0, irq_req}, 16'd0);
    ser_irq = 0;
  endtask

  task automatic t_level;
    wr(0, 8'h81); // R2 global + external 0
    ext_irq_n[0] = 0;
    step(3);
    chk("R10 not before 4th edge", {15'd0, irq_req}, 16'd0);
    step(1);
    chk("R10 req at 4th edge", {15'd0, irq_req}, 16'd1);
    chk("R3 level vec", irq_vec, 16'h0003);
    ext_irq_n[0] = 1; step(5);
    chk("R3 level withdrawn", {15'd0, irq_req}, 16'd0);
    quiet();
  endtask

  task automatic t_edge;
    wr(1, 8'h01); wr(0, 8'h81);
    ext_irq_n[0] = 0; step(2); ext_irq_n[0] = 1;
    step(6);
    chk("R4 edge flag held", {15'd0, irq_req}, 16'd1);
    chk("R4 edge vec", irq_vec, 16'h0003);
    ack_pulse();
    chk("R5 drop after ack", {15'd0, irq_req}, 16'd0);
    step(3);
    chk("R5 edge flag cleared", {15'd0, irq_req}, 16'd0);
    quiet();
  endtask

  task automatic t_priority;
    wr(0, 8'h9F);
    ext_irq_n = 2'b00; tmr_ovf = 2'b11; ser_irq = 1; step(5);
    chk("R6 R7 ext0 first", irq_vec, 16'h0003);
    ext_irq_n[0] = 1; step(5);
    chk("R6 R7 timer0 second", irq_vec, 16'h000B);
    tmr_ovf[0] = 0; step(3);
    chk("R6 R7 ext1 third", irq_vec, 16'h0013);
    ext_irq_n[1] = 1; step(5);
    chk("R6 R7 timer1 fourth", irq_vec, 16'h001B);
    tmr_ovf[1] = 0; step(3);
    chk("R6 R7 serial last", irq_vec, 16'h0023);
    chk("R6 req", {15'd0, irq_req}, 16'd1);
    quiet();
  endtask

  task automatic t_global;
    ser_irq = 1; wr(0, 8'h10); step(4);
    chk("R8 global off", {15'd0, irq_req}, 16'd0);
    wr(0, 8'h90); step(1);
    chk("R8 global on", {15'd0, irq_req}, 16'd1);
    chk("R8 vec", irq_vec, 16'h0023);
    ser_irq = 0; quiet();
    wr(1, 8'h02); wr(0, 8'h04);
    ext_irq_n[1] = 0; step(2); ext_irq_n[1] = 1; step(6);
    chk("R8 edge masked", {15'd0, irq_req}, 16'd0);
    wr(0, 8'h84); step(1);
    chk("R8 edge flag kept", {15'd0, irq_req}, 16'd1);
    chk("R8 R2 ext1 vec", irq_vec, 16'h0013);
    ack_pulse();
    quiet();
  endtask

  task automatic t_mask;
    tmr_ovf = 2'b11; wr(0, 8'h88); step(3);
    chk("R9 timer0 masked", irq_vec, 16'h001B);
    chk("R9 req", {15'd0, irq_req}, 16'd1);
    quiet();
  endtask

  task automatic t_internal_ack;
    ser_irq = 1; wr(0, 8'h90); step(3);
    ack_pulse();
    chk("R11 drop", {15'd0, irq_req}, 16'd0);
    step(1);
    chk("R11 returns", {15'd0, irq_req}, 16'd1);
    chk("R11 vec", irq_vec, 16'h0023);
    quiet();
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    t_reset();
    t_level();
    t_edge();
    t_priority();
    t_global();
    t_mask();
    t_internal_ack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule